// File: doc/BRIEF.md
# SDRAM Byte-Lane Mask Data Path

This block applies the per-byte data masks of a 32-bit SDRAM data bus. The bus is split into four byte lanes, and one mask bit belongs to each lane. The read side and the write side use the same mask bits with different timing.

On a read, the mask bits captured with the read cycle are held back by two clocks. They then set the output enable of each lane and gate the read data taken from the memory array. A masked lane is left at high impedance and its data bits are held at zero. When no read result falls due, every lane stays disabled.

On a write, the mask bits act in the same cycle as the data they go with. They become per-byte write strobes for a memory-array port, and the write data is passed through unchanged in that same cycle. Burst addressing and command sequencing belong to the surrounding controller.

Top module: `sdram_lane_mask`

## Requirements
- R1: While reset is high, and for the first two cycles after it falls, `dq_oe` is 0 and `rd_data` is 0. Reset is synchronous and active-high.
- R2: If `rd_active` is 1 in cycle t and `dqm[i]` is 0, then `dq_oe[i]` is 1 in cycle t+2. In that cycle, lane i of `rd_data` equals lane i of `arr_rd_data` as presented in cycle t+1.
- R3: If `rd_active` is 1 in cycle t and `dqm[i]` is 1, then `dq_oe[i]` is 0 in cycle t+2 and lane i of `rd_data` is 0.
- R4: If `rd_active` is 0 in cycle t, then all of `dq_oe` is 0 in cycle t+2, whatever value `dqm` had.
- R5: In the same cycle, `wr_be[i]` is 1 exactly when `wr_valid` is 1 and `dqm[i]` is 0. In that same cycle `arr_wr_data` equals `wr_data`.
- R6: A write with `dqm[i]` = 1 leaves byte lane i of the array word unchanged, and a write with `dqm[i]` = 0 stores that byte.
- R7: Lane i covers data bits 8i+7 down to 8i, and mask bit i controls only that lane (bit 0 is the lowest byte).
- R8: Reads in consecutive cycles each use their own mask two cycles later. No mask is held over into the next cycle's result.
- R9: A reset in the cycle after a read cancels that read: its lanes are not enabled afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_active | input | 1 | This cycle is a read data cycle whose mask is captured |
| wr_valid | input | 1 | This cycle carries write data |
| dqm | input | 4 | Per-lane mask, 1 = masked |
| wr_data | input | 32 | Write data from the bus |
| arr_rd_data | input | 32 | Data read from the memory array, one cycle after the read cycle |
| dq_oe | output | 4 | Per-lane drive enable, 0 = high impedance |
| rd_data | output | 32 | Read data, masked lanes held at zero |
| wr_be | output | 4 | Per-byte write strobes to the array |
| arr_wr_data | output | 32 | Write data to the array |

## Verification
A read mask that is lost or delayed inside the two-stage delay line shows up two clocks after the read cycle. It appears as a lane that is enabled one cycle too early or too late, or that carries stale data. The reference model therefore compares `dq_oe` and `rd_data` in every cycle, so such a fault is caught in the first cycle it affects. A stage that does not return to the all-masked state after reset or during idle cycles would let a lane drive with no read pending, and the idle and mid-flight reset sequences expose this. On the write side, a wrong strobe corrupts a byte of the bench's array word in the same cycle as the write, and the next cycle's compare of that word reports it.

// File: rtl/sdram_mask_pkg.sv
package sdram_mask_pkg;
  // Read masks act this many clocks after the read cycle; writes act in the same cycle.
  localparam int unsigned RD_LATENCY   = 2;
  localparam int unsigned DEF_LANES    = 4;
  localparam int unsigned DEF_LANE_W   = 8;
endpackage

// File: rtl/dqm_read_delay.sv
module dqm_read_delay
  import sdram_mask_pkg::*;
#(
  parameter int unsigned LANES = DEF_LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_active,
  input  logic [LANES-1:0] dqm,
  output logic [LANES-1:0] mask_early,
  output logic [LANES-1:0] mask_due
);
  // Shift chain of masks; a cycle without a read enters as all-masked.
  logic [LANES-1:0] stg [RD_LATENCY];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '1;
    else     stg[0] <= rd_active ? dqm : '1;
  end

  for (genvar k = 1; k < RD_LATENCY; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[k] <= '1;
      else     stg[k] <= stg[k-1];
    end
  end

  assign mask_early = stg[RD_LATENCY-2];
  assign mask_due   = stg[RD_LATENCY-1];
endmodule

// File: rtl/dq_lane_capture.sv
module dq_lane_capture #(
  parameter int unsigned LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lane_open,
  input  logic [LANE_W-1:0] arr_byte,
  output logic [LANE_W-1:0] out_byte
);
  // Registered so the byte lines up with the delayed mask stage.
  always_ff @(posedge clk) begin
    if (rst)            out_byte <= '0;
    else if (lane_open) out_byte <= arr_byte;
    else                out_byte <= '0;
  end
endmodule

// File: rtl/dqm_write_strobe.sv
module dqm_write_strobe #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8
) (
  input  logic                    wr_valid,
  input  logic [LANES-1:0]        dqm,
  input  logic [LANES*LANE_W-1:0] wr_data,
  output logic [LANES-1:0]        wr_be,
  output logic [LANES*LANE_W-1:0] arr_wr_data
);
  // Zero-latency path: the mask applies to the data in its own cycle.
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      wr_be[i] = wr_valid & ~dqm[i];
    end
  end
  assign arr_wr_data = wr_data;
endmodule

// File: rtl/sdram_lane_mask.sv
module sdram_lane_mask
  import sdram_mask_pkg::*;
#(
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned LANE_W = DEF_LANE_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rd_active,
  input  logic                    wr_valid,
  input  logic [LANES-1:0]        dqm,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [LANES*LANE_W-1:0] arr_rd_data,
  output logic [LANES-1:0]        dq_oe,
  output logic [LANES*LANE_W-1:0] rd_data,
  output logic [LANES-1:0]        wr_be,
  output logic [LANES*LANE_W-1:0] arr_wr_data
);
  localparam int unsigned DW = LANES * LANE_W;

  logic [LANES-1:0] mask_early;
  logic [LANES-1:0] mask_due;

  dqm_read_delay #(.LANES(LANES)) u_delay (
    .clk        (clk),
    .rst        (rst),
    .rd_active  (rd_active),
    .dqm        (dqm),
    .mask_early (mask_early),
    .mask_due   (mask_due)
  );

  assign dq_oe = ~mask_due;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    dq_lane_capture #(.LANE_W(LANE_W)) u_cap (
      .clk       (clk),
      .rst       (rst),
      .lane_open (~mask_early[i]),
      .arr_byte  (arr_rd_data[i*LANE_W +: LANE_W]),
      .out_byte  (rd_data[i*LANE_W +: LANE_W])
    );
  end

  dqm_write_strobe #(.LANES(LANES), .LANE_W(LANE_W)) u_wr (
    .wr_valid    (wr_valid),
    .dqm         (dqm),
    .wr_data     (wr_data[DW-1:0]),
    .wr_be       (wr_be),
    .arr_wr_data (arr_wr_data)
  );
endmodule

// File: rtl/sdram_lane_mask_chk.sv
module sdram_lane_mask_chk #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    rd_active,
  input logic                    wr_valid,
  input logic [LANES-1:0]        dqm,
  input logic [LANES*LANE_W-1:0] arr_rd_data,
  input logic [LANES-1:0]        dq_oe,
  input logic [LANES*LANE_W-1:0] rd_data,
  input logic [LANES-1:0]        wr_be
);
  localparam int unsigned DW = LANES * LANE_W;

  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                since_rst <= '0;
    else if (since_rst != 3) since_rst <= since_rst + 2'd1;
  end

  function automatic logic [DW-1:0] fill(input logic [LANES-1:0] m);
    logic [DW-1:0] r;
    for (int i = 0; i < LANES; i++) r[i*LANE_W +: LANE_W] = {LANE_W{m[i]}};
    return r;
  endfunction

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    (since_rst <= 2'd1) |-> (dq_oe == '0 && rd_data == '0));

  a_r2_oe_two_later: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2 && $past(rd_active, 2)) |-> (dq_oe == ~$past(dqm, 2)));

  a_r4_idle_no_drive: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2 && !$past(rd_active, 2)) |-> (dq_oe == '0));

  a_r2_open_lane_data: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd1) |-> ((rd_data & fill(dq_oe)) == ($past(arr_rd_data) & fill(dq_oe))));

  a_r3_closed_lane_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_data & ~fill(dq_oe)) == '0);

  a_r5_no_strobe_idle: assert property (@(posedge clk) disable iff (rst)
    !wr_valid |-> (wr_be == '0));

  a_r5_open_lane_strobes: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> ((wr_be | dqm) == '1));

  a_r6_masked_no_strobe: assert property (@(posedge clk) disable iff (rst)
    (wr_be & dqm) == '0);
endmodule

bind sdram_lane_mask sdram_lane_mask_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rd_active   (rd_active),
  .wr_valid    (wr_valid),
  .dqm         (dqm),
  .arr_rd_data (arr_rd_data),
  .dq_oe       (dq_oe),
  .rd_data     (rd_data),
  .wr_be       (wr_be)
);

// File: tb/sdram_lane_mask_tb.sv
`timescale 1ns/1ps
module sdram_lane_mask_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_active = 1'b0;
  logic        wr_valid = 1'b0;
  logic [3:0]  dqm = 4'hF;
  logic [31:0] wr_data = '0;
  logic [31:0] arr_rd_data = '0;
  logic [3:0]  dq_oe;
  logic [31:0] rd_data;
  logic [3:0]  wr_be;
  logic [31:0] arr_wr_data;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int n      = 0;
  logic [31:0] mem = '0;

  sdram_lane_mask u_dut (
    .clk(clk), .rst(rst), .rd_active(rd_active), .wr_valid(wr_valid), .dqm(dqm),
    .wr_data(wr_data), .arr_rd_data(arr_rd_data), .dq_oe(dq_oe), .rd_data(rd_data),
    .wr_be(wr_be), .arr_wr_data(arr_wr_data)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    logic        rd;
    logic [3:0]  m;
    logic [31:0] a;
  } smp_t;
  smp_t hist[$];

  // Reference model: history of edge samples, newest first; plus the array word.
  always @(posedge clk) begin
    if (rst) hist.delete();
    else begin
      hist.push_front('{rd_active, dqm, arr_rd_data});
      if (hist.size() > 2) void'(hist.pop_back());
    end
    for (int i = 0; i < 4; i++)
      if (wr_be[i]) mem[i*8 +: 8] = arr_wr_data[i*8 +: 8];
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL R1 watchdog expired: cycles=%0d expected<=%0d", cyc, 20000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic r, logic rd, logic [3:0] m, logic wv, logic [31:0] wd);
    logic [3:0]  e_oe;
    logic [31:0] e_rd;
    @(negedge clk);
    rst = r; rd_active = rd; dqm = m; wr_valid = wv; wr_data = wd;
    n++;
    arr_rd_data = 32'(n) * 32'h9E37_79B1;
    #0.5;
    e_oe = 4'h0;
    if (hist.size() >= 2 && hist[1].rd) e_oe = ~hist[1].m;
    e_rd = '0;
    for (int i = 0; i < 4; i++)
      if (e_oe[i]) e_rd[i*8 +: 8] = hist[0].a[i*8 +: 8];
    cmp(tag, "dq_oe", {28'd0, dq_oe}, {28'd0, e_oe});
    cmp(tag, "rd_data", rd_data, e_rd);
    cmp(tag, "wr_be", {28'd0, wr_be}, {28'd0, (wv ? ~m : 4'h0)});
    cmp(tag, "arr_wr_data", arr_wr_data, wd);
  endtask

  task automatic idle(string tag, int k);
    for (int j = 0; j < k; j++) step(tag, 1'b0, 1'b0, 4'h0, 1'b0, '0);
  endtask

  initial begin
    // R1: reset and the first cycles after it
    for (int j = 0; j < 3; j++) step("R1", 1'b1, 1'b0, 4'h0, 1'b0, '0);
    idle("R1", 2);
    cmp("R1", "dq_oe after reset", {28'd0, dq_oe}, 32'd0);

    // R2: unmasked reads
    step("R2", 1'b0, 1'b1, 4'h0, 1'b0, '0);
    step("R2", 1'b0, 1'b0, 4'h0, 1'b0, '0);
    step("R2", 1'b0, 1'b0, 4'h0, 1'b0, '0);
    cmp("R2", "all lanes driven two cycles later", {28'd0, dq_oe}, 32'hF);
    idle("R2", 2);

    // R3: masked reads
    step("R3", 1'b0, 1'b1, 4'hF, 1'b0, '0);
    step("R3", 1'b0, 1'b1, 4'hA, 1'b0, '0);
    idle("R3", 3);

    // R4: no read, mask low
    for (int j = 0; j < 4; j++) step("R4", 1'b0, 1'b0, 4'h0, 1'b0, '0);

    // R7: walk a single open lane
    for (int i = 0; i < 4; i++) begin
      step("R7", 1'b0, 1'b1, ~(4'b1 << i), 1'b0, '0);
      idle("R7", 2);
    end

    // R8: back-to-back reads with changing masks
    step("R8", 1'b0, 1'b1, 4'h3, 1'b0, '0);
    step("R8", 1'b0, 1'b1, 4'hC, 1'b0, '0);
    step("R8", 1'b0, 1'b1, 4'h5, 1'b0, '0);
    step("R8", 1'b0, 1'b1, 4'h0, 1'b0, '0);
    step("R8", 1'b0, 1'b0, 4'hF, 1'b0, '0);
    idle("R8", 2);

    // R5: write strobes and data pass-through
    step("R5", 1'b0, 1'b0, 4'h0, 1'b1, 32'hDEAD_BEEF);
    step("R5", 1'b0, 1'b0, 4'h6, 1'b1, 32'h0BAD_F00D);
    step("R5", 1'b0, 1'b0, 4'h0, 1'b0, 32'h1234_5678);

    // R6: masked bytes keep their stored value
    @(negedge clk);
    mem = 32'hA5A5_A5A5;
    step("R6", 1'b0, 1'b0, 4'b0101, 1'b1, 32'h1122_3344);
    step("R6", 1'b0, 1'b0, 4'h0, 1'b0, '0);
    cmp("R6", "array word", mem, 32'h11A5_33A5);
    step("R6", 1'b0, 1'b0, 4'hF, 1'b1, 32'hFFFF_FFFF);
    step("R6", 1'b0, 1'b0, 4'h0, 1'b0, '0);
    cmp("R6", "array word fully masked", mem, 32'h11A5_33A5);

    // R9: reset right after a read
    step("R9", 1'b0, 1'b1, 4'h0, 1'b0, '0);
    step("R9", 1'b1, 1'b0, 4'h0, 1'b0, '0);
    step("R9", 1'b0, 1'b0, 4'h0, 1'b0, '0);
    cmp("R9", "read cancelled by reset", {28'd0, dq_oe}, 32'd0);
    idle("R9", 2);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule